// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Sequencer

This block is the control logic that sits beside a clock synthesizer with two outputs: a buffered copy of the input reference and a frequency-modulated main clock. It watches three control pins: an active-low power-down, an active-low reference-output enable and a test pin. It turns them into an enable and a high-impedance control for each output, plus a request that powers the synthesizer core down. The clocks themselves and any analog lock sensing live elsewhere.

Every control pin is first passed through a synchronizer clocked by the reference clock. A decision register follows, so a change on any pin reaches the outputs after a fixed number of reference cycles. That number is `SYNC_STAGES + 1`, which is 3 by default and stays inside the four-cycle budget. When the core leaves power-down, a lock timer holds both enables off for `LOCK_CYCLES` further cycles. This interval stands in for the time the synthesizer needs to settle, about 5 ms in reference cycles. When a high-impedance condition and an enable condition hold together, the high-impedance condition wins.

Top module: `ckc_clkout_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_pd_req` is 1 and `main_oe`, `main_hiz`, `ref_oe` and `ref_hiz` are all 0.
- R2: When `pwrdn_n` is 0, `core_pd_req` is 1 and both `main_oe` and `ref_oe` are 0.
- R3: `ref_oe` is 1 only while `refen_n` is 0, `pwrdn_n` is 1 and the lock wait has finished.
- R4: When `test_i` and `refen_n` are both 1, `main_hiz` is 1 and `main_oe` is 0. Otherwise `main_hiz` is 0.
- R5: When `pwrdn_n` and `refen_n` are both 1, `ref_hiz` is 1 and `ref_oe` is 0. Otherwise `ref_hiz` is 0.
- R6: A pin change shows at the outputs after exactly `SYNC_STAGES + 1` rising edges of `clk_ref` (3 with defaults). The output has not changed after one edge fewer.
- R7: After `pwrdn_n` rises and stays high, `core_pd_req` falls after `SYNC_STAGES + 1` edges. `main_oe` and `ref_oe` stay 0 until `SYNC_STAGES + LOCK_CYCLES + 1` edges have passed. From then on they follow R3 to R5.
- R8: `main_oe` and `main_hiz` are never 1 together, and `ref_oe` and `ref_hiz` are never 1 together.
- R9: Changes on `refen_n` or `test_i` while the core is powered up and locked do not restart the lock wait. They take effect after the R6 delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down pin |
| refen_n | input | 1 | Active-low reference-output enable pin |
| test_i | input | 1 | Test pin; with `refen_n` high it floats the main output |
| core_pd_req | output | 1 | Request to power down the synthesizer core |
| main_oe | output | 1 | Enable for the modulated main clock output |
| main_hiz | output | 1 | High-impedance control for the main clock output |
| ref_oe | output | 1 | Enable for the buffered reference output |
| ref_hiz | output | 1 | High-impedance control for the reference output |

## Verification
The assertions assume that the pins are asynchronous, level-type signals, so they are always checked after the synchronizer. They also assume that `LOCK_CYCLES` is at least 1, so that the lock timer is never already expired on the cycle power-down ends. The stimulus changes pins only on falling clock edges. It keeps power-down pulses rare, so that lock waits run to completion most of the time. Now and then it drops power-down in the middle of a wait, to show that the wait restarts from its full length.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
  // Synchronized control pins, packed MSB first as {pd_n, refen_n, test}
  typedef struct packed {
    logic pd_n;
    logic refen_n;
    logic test;
  } ckc_pins_t;

  localparam int unsigned PIN_W = $bits(ckc_pins_t);
  // Safe idle value: powered down, reference disabled, test inactive
  localparam ckc_pins_t PIN_IDLE = '{pd_n: 1'b0, refen_n: 1'b1, test: 1'b0};
endpackage

// File: rtl/ckc_sync.sv
module ckc_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ckc_lock_timer.sv
module ckc_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic lock_done
);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;

  // Reloaded while powered down, counts to zero once power-down ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= LOAD;
    else if (!pd_n)       cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign lock_done = (cnt == '0);

  // R7: power-down reloads the full wait
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> cnt == LOAD);
  // R7: each powered-up cycle consumes exactly one count
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R9: once expired, the wait is not restarted while powered up
  a_r9_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && lock_done) |=> lock_done);
endmodule

// File: rtl/ckc_out_ctl.sv
module ckc_out_ctl
  import ckc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ckc_pins_t pins,
  input  logic      lock_done,
  output logic      core_pd_req,
  output logic      main_oe,
  output logic      main_hiz,
  output logic      ref_oe,
  output logic      ref_hiz
);
  logic main_float, ref_float, run_ok;
  logic main_oe_d, ref_oe_d;

  always_comb begin
    main_float = pins.test & pins.refen_n;
    ref_float  = pins.pd_n & pins.refen_n;
    run_ok     = pins.pd_n & lock_done;
    // High impedance takes priority over enabling
    main_oe_d  = run_ok & ~main_float;
    ref_oe_d   = run_ok & ~pins.refen_n & ~ref_float;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_pd_req <= 1'b1;
      main_oe     <= 1'b0;
      main_hiz    <= 1'b0;
      ref_oe      <= 1'b0;
      ref_hiz     <= 1'b0;
    end else begin
      core_pd_req <= ~pins.pd_n;
      main_oe     <= main_oe_d;
      main_hiz    <= main_float;
      ref_oe      <= ref_oe_d;
      ref_hiz     <= ref_float;
    end
  end

  a_r2_pd_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pins.pd_n) |-> (core_pd_req && !main_oe && !ref_oe));
  a_r3_ref_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ref_oe |-> ($past(!pins.refen_n) && $past(lock_done)));
  a_r4_main_float: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pins.test && pins.refen_n) |-> (main_hiz && !main_oe));
  a_r5_ref_float: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pins.pd_n && pins.refen_n) |-> (ref_hiz && !ref_oe));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({main_oe, main_hiz}) <= 1 && $countones({ref_oe, ref_hiz}) <= 1);
endmodule

// File: rtl/ckc_clkout_ctrl.sv
module ckc_clkout_ctrl
  import ckc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOCK_CYCLES = 80000
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic pwrdn_n,
  input  logic refen_n,
  input  logic test_i,
  output logic core_pd_req,
  output logic main_oe,
  output logic main_hiz,
  output logic ref_oe,
  output logic ref_hiz
);
  ckc_pins_t raw_pins, s_pins;
  logic [PIN_W-1:0] s_vec;
  logic lock_done;

  assign raw_pins = '{pd_n: pwrdn_n, refen_n: refen_n, test: test_i};

  ckc_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk_ref),
    .rst_n(rst_n),
    .d    (raw_pins),
    .q    (s_vec)
  );

  assign s_pins = ckc_pins_t'(s_vec);

  ckc_lock_timer #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_lock (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .pd_n     (s_pins.pd_n),
    .lock_done(lock_done)
  );

  ckc_out_ctl u_out (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .pins       (s_pins),
    .lock_done  (lock_done),
    .core_pd_req(core_pd_req),
    .main_oe    (main_oe),
    .main_hiz   (main_hiz),
    .ref_oe     (ref_oe),
    .ref_hiz    (ref_hiz)
  );
endmodule

// File: tb/sim_ckc_clkout_ctrl.sv
module sim_ckc_clkout_ctrl;
  localparam int CLK_P = 10;
  localparam int LOCK  = 20;
  localparam int DLY   = 3;      // SYNC_STAGES + 1 with default SYNC_STAGES
  localparam int HMAX  = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn_n = 1'b0, refen_n = 1'b1, test_i = 1'b0;
  logic core_pd_req, main_oe, main_hiz, ref_oe, ref_hiz;

  int nchk = 0, nbad = 0;
  int t = 0;                     // rising edges since reset release
  logic h_pd [HMAX], h_re [HMAX], h_te [HMAX];
  int   h_run [HMAX];            // consecutive edges with pd high, ending here

  always #(CLK_P/2) clk = ~clk;

  ckc_clkout_ctrl #(.SYNC_STAGES(2), .LOCK_CYCLES(LOCK)) u0 (
    .clk_ref(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .refen_n(refen_n),
    .test_i(test_i), .core_pd_req(core_pd_req), .main_oe(main_oe),
    .main_hiz(main_hiz), .ref_oe(ref_oe), .ref_hiz(ref_hiz));

  task automatic chk(string req, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, t, act, exp);
    end
  endtask

  // Expected {core_pd, main_oe, main_hiz, ref_oe, ref_hiz} from pins and lock state
  function automatic logic [4:0] expect_outs(logic pd, logic re, logic te, logic locked);
    logic mh, rh;
    mh = te & re;
    rh = pd & re;
    return {~pd, pd & locked & ~mh, mh, pd & locked & ~re & ~rh, rh};
  endfunction

  // Apply pins for the next edge, clock once, check outputs
  task automatic step(string req, logic pd, logic re, logic te);
    logic [4:0] e;
    int k;
    pwrdn_n = pd; refen_n = re; test_i = te;
    t++;
    h_pd[t+1] = pd; h_re[t+1] = re; h_te[t+1] = te;
    h_run[t+1] = pd ? h_run[t] + 1 : 0;
    @(posedge clk);
    @(negedge clk);
    k = t - (DLY - 1) + 1;       // history slot of the edge now visible
    e = expect_outs(h_pd[k], h_re[k], h_te[k], h_run[k] >= LOCK + 1);
    chk(req, "core_pd_req", core_pd_req, e[4]);
    chk(req, "main_oe",     main_oe,     e[3]);
    chk(req, "main_hiz",    main_hiz,    e[2]);
    chk(req, "ref_oe",      ref_oe,      e[1]);
    chk(req, "ref_hiz",     ref_hiz,     e[0]);
    chk("R8", "oe/hiz overlap", (main_oe & main_hiz) | (ref_oe & ref_hiz), 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    nbad++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic pd, re, te;
    int unsigned seed;
    seed = 32'h5eed_c10c;
    void'($urandom(seed));
    for (int i = 0; i < 2; i++) begin
      h_pd[i] = 1'b0; h_re[i] = 1'b1; h_te[i] = 1'b0; h_run[i] = 0;
    end
    // R1: reset values while reset is held
    repeat (3) @(posedge clk);
    @(negedge clk);
    pwrdn_n = 1'b1; refen_n = 1'b0; test_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "core_pd_req", core_pd_req, 1'b1);
    chk("R1", "main_oe", main_oe, 1'b0);
    chk("R1", "main_hiz", main_hiz, 1'b0);
    chk("R1", "ref_oe", ref_oe, 1'b0);
    chk("R1", "ref_hiz", ref_hiz, 1'b0);
    rst_n = 1'b1;

    // R7: power-up, exact lock release edge
    for (int i = 0; i < LOCK + DLY + 4; i++) step("R7", 1'b1, 1'b0, 1'b0);
    chk("R7", "ref_oe after lock", ref_oe, 1'b1);
    chk("R7", "main_oe after lock", main_oe, 1'b1);

    // R6: refen_n rise, old value for DLY-1 edges, new value on edge DLY
    step("R6", 1'b1, 1'b1, 1'b0);
    chk("R6", "ref_oe edge 1", ref_oe, 1'b1);
    step("R6", 1'b1, 1'b1, 1'b0);
    chk("R6", "ref_oe edge 2", ref_oe, 1'b1);
    step("R6", 1'b1, 1'b1, 1'b0);
    chk("R6", "ref_oe edge 3", ref_oe, 1'b0);
    chk("R5", "ref_hiz edge 3", ref_hiz, 1'b1);

    // R4: test with refen_n high floats the main output
    for (int i = 0; i < DLY + 1; i++) step("R4", 1'b1, 1'b1, 1'b1);
    chk("R4", "main_hiz", main_hiz, 1'b1);
    chk("R4", "main_oe", main_oe, 1'b0);

    // R9: back to enabled without a new lock wait
    for (int i = 0; i < DLY; i++) step("R9", 1'b1, 1'b0, 1'b0);
    chk("R9", "ref_oe no relock", ref_oe, 1'b1);
    chk("R3", "ref_oe with refen_n low", ref_oe, 1'b1);

    // R2: power-down with refen_n low; reference output held low, not floated
    for (int i = 0; i < DLY + 2; i++) step("R2", 1'b0, 1'b0, 1'b1);
    chk("R2", "core_pd_req", core_pd_req, 1'b1);
    chk("R2", "ref_oe", ref_oe, 1'b0);
    chk("R5", "ref_hiz while powered down", ref_hiz, 1'b0);

    // R7: power-down in the middle of a lock wait restarts it
    for (int i = 0; i < LOCK / 2; i++) step("R7", 1'b1, 1'b0, 1'b0);
    step("R7", 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < LOCK + DLY + 2; i++) step("R7", 1'b1, 1'b0, 1'b0);

    // Random phase: mostly powered, rare power-down pulses
    pd = 1'b1; re = 1'b0; te = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 149) == 0) pd = ~pd;
      if ($urandom_range(0, 7) == 0)   re = ~re;
      if ($urandom_range(0, 9) == 0)   te = ~te;
      step("R3", pd, re, te);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule